// File: doc/BRIEF.md
# SPI Memory Upload Command Interface

This block is an SPI target that lets an external controller fill a byte-wide memory and read it back. It also drives a few system-control signals. The controller picks one of two channels with a pair of active-low selects. The first byte of every select window is an opcode and the bytes after it are that opcode's arguments or data. Deasserting the select closes the command.

All SPI inputs pass through two-flop synchronizers into the system clock, and edge detection happens there. The SPI clock idles high. The target samples MOSI on the rising (trailing) edge and updates MISO on the falling (leading) edge, most significant bit first.

On the memory side the block keeps a single transfer address. It advances by one for every completed access, both writes and reads. Streamed writes go straight out through a request/acknowledge port. Reads are fetched ahead into a 16-entry buffer, and read-stream dummy bytes drain that buffer onto MISO.

Top module: `spi_upload_ctrl`

## Requirements
- R1: After reset, `soft_rst_o`=0, `cfg_o`=0, `mem_req_o`=0, `mem_addr_o`=0, `underrun_o`=0 and `spi_miso_o`=0.
- R2: A byte is assembled from MOSI on rising SCK edges, MSB first. MISO presents bit 7 of the outgoing byte after the first falling edge of a byte and shifts one bit on each later falling edge.
- R3: `spi_sel_n_i`=2'b10 (bit 0 low) addresses the memory channel and 2'b01 (bit 1 low) addresses the control channel. With 2'b11 or 2'b00 no bytes are decoded. An opcode of one channel sent on the other channel has no effect.
- R4: On the control channel, opcode 0x11 sets `soft_rst_o` to 1 and opcode 0x10 clears it.
- R5: On the control channel, opcode 0x23 takes two bytes that load `cfg_o`: the first byte goes to bits 7:0 and the second to bits 15:8.
- R6: On the memory channel, opcode 0x80 takes four bytes that load the transfer address, least significant byte first.
- R7: On the memory channel, opcode 0x81 takes one direction byte. A byte with bit 7 set (0x80) selects read and a byte with bit 7 clear (0x00) selects write.
- R8: Opcode 0xB0 in write direction stores each following byte at the current address and then increments the address. In read direction its data bytes are ignored.
- R9: Opcode 0x84 takes two bytes, low first, holding N-1. In read direction it flushes the buffer and fetches N bytes upward from the current address. The buffer holds at most 16 bytes ahead. In write direction the opcode starts nothing.
- R10: During opcode 0xA0, each following byte returns the next fetched byte in address order. The opcode byte itself, and every byte of every other command, returns 0x00.
- R11: When a 0xA0 byte finds the buffer empty, it returns 0x00 and sets the sticky `underrun_o`. A read start by 0x84 clears `underrun_o`.
- R12: Asserting or releasing the soft reset leaves the transfer address unchanged.
- R13: `mem_req_o` stays high with `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stable until `mem_ack_i`. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sck_i | input | 1 | SPI clock, idles high |
| spi_mosi_i | input | 1 | Serial data in |
| spi_sel_n_i | input | 2 | Channel selects, active low: bit 0 memory, bit 1 control |
| spi_miso_o | output | 1 | Serial data out |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Transfer address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with ack |
| mem_ack_i | input | 1 | Access complete, one-cycle pulse |
| soft_rst_o | output | 1 | Soft reset level |
| cfg_o | output | 16 | Configuration word |
| underrun_o | output | 1 | Sticky read-buffer underrun |

## Verification
The assertions assume the following about the inputs:
- `mem_ack_i` only comes while a request is up.
- No new address load or data byte arrives while an access is still outstanding.
- The SPI clock runs at least four system cycles per half period.

The bench stays within these limits. It holds each SCK phase for eight system cycles and answers every request with a one-cycle acknowledge. Before it loads a new address, starts a read or sends more data, it waits until all fetches and writes have finished.

// File: rtl/spi_uif_pkg.sv
package spi_uif_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 4;
  localparam int LEN_BYTES  = 2;
  localparam int CFG_BYTES  = 2;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int LEN_W      = LEN_BYTES * BYTE_W;
  localparam int CFG_W      = CFG_BYTES * BYTE_W;

  localparam logic [7:0] OP_SRST_ON  = 8'h11;
  localparam logic [7:0] OP_SRST_OFF = 8'h10;
  localparam logic [7:0] OP_CFG      = 8'h23;
  localparam logic [7:0] OP_ADDR     = 8'h80;
  localparam logic [7:0] OP_DIR      = 8'h81;
  localparam logic [7:0] OP_WSTREAM  = 8'hB0;
  localparam logic [7:0] OP_RLEN     = 8'h84;
  localparam logic [7:0] OP_RSTREAM  = 8'hA0;
endpackage

// File: rtl/spi_uif_frontend.sv
module spi_uif_frontend #(
  parameter int SYNC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic [1:0] sel_n_i,
  input  logic [7:0] tx_byte_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic [2:0] byte_idx_o,
  output logic       data_ph_o,
  output logic       win_act_o,
  output logic       win_mem_o,
  output logic       tx_load_o,
  output logic       miso_o
);
  localparam int NSIG = 4;

  logic [SYNC-1:0][NSIG-1:0] sr_q;
  logic [NSIG-1:0] raw, syn;
  logic sck_q, act_q, mem_q, vld_q;
  logic [2:0] bit_cnt_q, idx_q, idx_rep_q;
  logic [7:0] sh_in_q, byte_q, tx_sh_q;
  logic act, rise, fall, start;

  assign raw = {sck_i, mosi_i, sel_n_i};
  assign syn = sr_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[SYNC-2:0], raw};

  // exactly one select low
  assign act   = ^syn[1:0];
  assign start = act && !act_q;
  assign rise  = act && !start && syn[3] && !sck_q;
  assign fall  = act && !start && !syn[3] && sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b1; act_q <= 1'b0; mem_q <= 1'b0; vld_q <= 1'b0;
      bit_cnt_q <= '0; idx_q <= '0; idx_rep_q <= '0;
      sh_in_q <= '0; byte_q <= '0; tx_sh_q <= '0;
    end else begin
      sck_q <= syn[3];
      act_q <= act;
      vld_q <= 1'b0;
      if (start) begin
        mem_q <= !syn[0];
        bit_cnt_q <= '0;
        idx_q <= '0;
        tx_sh_q <= '0;
      end else if (rise) begin
        sh_in_q <= {sh_in_q[6:0], syn[2]};
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          vld_q <= 1'b1;
          byte_q <= {sh_in_q[6:0], syn[2]};
          idx_rep_q <= idx_q;
          if (idx_q != 3'd7) idx_q <= idx_q + 3'd1;
        end
      end else if (fall) begin
        if (bit_cnt_q == 3'd0) tx_sh_q <= tx_byte_i;
        else                   tx_sh_q <= {tx_sh_q[6:0], 1'b0};
      end
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
  assign byte_idx_o = idx_rep_q;
  assign data_ph_o  = idx_q != 3'd0;
  assign win_act_o  = act_q;
  assign win_mem_o  = mem_q;
  assign tx_load_o  = fall && (bit_cnt_q == 3'd0);
  assign miso_o     = tx_sh_q[7];

  // R2
  byte_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(act));
endmodule

// File: rtl/spi_uif_prefetch.sv
module spi_uif_prefetch #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  assign empty_o = cnt_q == '0;
  assign full_o  = cnt_q == (PW+1)'(DEPTH);
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i)
    if (push_i && !flush_i) mem_q[wp_q] <= din_i;

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R11
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/spi_uif_decoder.sv
module spi_uif_decoder
  import spi_uif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [2:0]        byte_idx_i,
  input  logic              data_ph_i,
  input  logic              win_act_i,
  input  logic              win_mem_i,
  input  logic              tx_load_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_full_i,
  output logic              fifo_push_o,
  output logic              fifo_pop_o,
  output logic              fifo_flush_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  output logic              soft_rst_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              underrun_o
);
  logic [7:0]        cmd_q, len_lo_q, wdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W:0]    remain_q;
  logic [CFG_W-1:0]  cfg_q;
  logic dir_rd_q, wr_pend_q, req_q, we_q, soft_q, und_q;
  logic stream_rd, rd_go, rd_start;

  assign stream_rd = win_act_i && win_mem_i && data_ph_i && (cmd_q == OP_RSTREAM);
  assign rd_go     = (remain_q != '0) && !fifo_full_i && !wr_pend_q;
  assign rd_start  = byte_vld_i && win_mem_i && (cmd_q == OP_RLEN)
                     && (byte_idx_i == 3'd2) && dir_rd_q;

  assign fifo_pop_o   = tx_load_i && stream_rd && !fifo_empty_i;
  assign fifo_push_o  = req_q && mem_ack_i && !we_q;
  assign fifo_flush_o = rd_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0; len_lo_q <= '0; wdata_q <= '0; addr_q <= '0; remain_q <= '0;
      cfg_q <= '0; dir_rd_q <= 1'b0; wr_pend_q <= 1'b0; req_q <= 1'b0;
      we_q <= 1'b0; soft_q <= 1'b0; und_q <= 1'b0;
    end else begin
      // memory access sequencer, writes first
      if (!req_q) begin
        if (wr_pend_q) begin
          req_q <= 1'b1; we_q <= 1'b1;
        end else if (rd_go) begin
          req_q <= 1'b1; we_q <= 1'b0;
        end
      end else if (mem_ack_i) begin
        req_q  <= 1'b0;
        addr_q <= addr_q + 1'b1;
        if (we_q) wr_pend_q <= 1'b0;
        else      remain_q  <= remain_q - 1'b1;
      end

      if (tx_load_i && stream_rd && fifo_empty_i) und_q <= 1'b1;

      if (byte_vld_i) begin
        if (byte_idx_i == 3'd0) begin
          cmd_q <= byte_i;
          if (!win_mem_i) begin
            if (byte_i == OP_SRST_ON)  soft_q <= 1'b1;
            if (byte_i == OP_SRST_OFF) soft_q <= 1'b0;
          end
        end else if (win_mem_i) begin
          case (cmd_q)
            OP_ADDR:
              for (int b = 0; b < ADDR_BYTES; b++)
                if (byte_idx_i == 3'(b + 1)) addr_q[8*b +: 8] <= byte_i;
            OP_DIR:
              if (byte_idx_i == 3'd1) dir_rd_q <= byte_i[7];
            OP_WSTREAM:
              if (!dir_rd_q) begin
                wr_pend_q <= 1'b1;
                wdata_q   <= byte_i;
              end
            OP_RLEN: begin
              if (byte_idx_i == 3'd1) len_lo_q <= byte_i;
              if (rd_start) begin
                remain_q <= {1'b0, byte_i, len_lo_q} + 1'b1;
                und_q    <= 1'b0;
              end
            end
            default: ;
          endcase
        end else if (cmd_q == OP_CFG) begin
          for (int b = 0; b < CFG_BYTES; b++)
            if (byte_idx_i == 3'(b + 1)) cfg_q[8*b +: 8] <= byte_i;
        end
      end
    end
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign soft_rst_o  = soft_q;
  assign cfg_o       = cfg_q;
  assign underrun_o  = und_q;

  // R13
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));
  // R13
  ack_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ack_i |-> mem_req_o);
  // R8
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && !byte_vld_i |=> mem_addr_o == $past(mem_addr_o) + 1'b1);
  // R4
  srst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_o) |-> $past(byte_vld_i && !win_mem_i));
  // R11
  und_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(tx_load_i && fifo_empty_i));
endmodule

// File: rtl/spi_upload_ctrl.sv
module spi_upload_ctrl
  import spi_uif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PF_DEPTH    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sck_i,
  input  logic              spi_mosi_i,
  input  logic [1:0]        spi_sel_n_i,
  output logic              spi_miso_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              soft_rst_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              underrun_o
);
  logic       byte_vld, data_ph, win_act, win_mem, tx_load;
  logic [7:0] rx_byte, tx_byte, pf_dout;
  logic [2:0] byte_idx;
  logic       pf_push, pf_pop, pf_flush, pf_empty, pf_full;

  assign tx_byte = pf_pop ? pf_dout : 8'h00;

  spi_uif_frontend #(.SYNC(SYNC_STAGES)) fe_i (
    .clk_i, .rst_ni,
    .sck_i(spi_sck_i), .mosi_i(spi_mosi_i), .sel_n_i(spi_sel_n_i),
    .tx_byte_i(tx_byte),
    .byte_vld_o(byte_vld), .byte_o(rx_byte), .byte_idx_o(byte_idx),
    .data_ph_o(data_ph), .win_act_o(win_act), .win_mem_o(win_mem),
    .tx_load_o(tx_load), .miso_o(spi_miso_o)
  );

  spi_uif_prefetch #(.DEPTH(PF_DEPTH), .W(8)) pf_i (
    .clk_i, .rst_ni,
    .flush_i(pf_flush), .push_i(pf_push), .din_i(mem_rdata_i),
    .pop_i(pf_pop), .dout_o(pf_dout), .empty_o(pf_empty), .full_o(pf_full)
  );

  spi_uif_decoder dec_i (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .byte_i(rx_byte), .byte_idx_i(byte_idx),
    .data_ph_i(data_ph), .win_act_i(win_act), .win_mem_i(win_mem),
    .tx_load_i(tx_load), .fifo_empty_i(pf_empty), .fifo_full_i(pf_full),
    .fifo_push_o(pf_push), .fifo_pop_o(pf_pop), .fifo_flush_o(pf_flush),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i,
    .soft_rst_o, .cfg_o, .underrun_o
  );
endmodule

// File: tb/spi_upload_ctrl_tb.sv
module spi_upload_ctrl_tb_top;
  localparam logic [1:0] MEM = 2'b10;
  localparam logic [1:0] SYS = 2'b01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b1, mosi = 1'b0;
  logic [1:0] sel_n = 2'b11;
  logic miso, req, we, ack = 1'b0, srst, und;
  logic [31:0] addr;
  logic [7:0] wdata, rdata = 8'h00;
  logic [15:0] cfg;
  logic [7:0] mem_m [256];
  logic [7:0] tx_buf [40];
  logic [7:0] rx_buf [40];
  int nchk = 0, nerr = 0, wr_acks = 0;

  always #5 clk = ~clk;

  spi_upload_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .spi_sck_i(sck), .spi_mosi_i(mosi),
    .spi_sel_n_i(sel_n), .spi_miso_o(miso), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_ack_i(ack),
    .soft_rst_o(srst), .cfg_o(cfg), .underrun_o(und)
  );

  function automatic logic [7:0] initv(int a);
    return 8'(a * 7 + 3);
  endfunction

  // memory model, one-cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_m[i] <= initv(i);
      ack <= 1'b0;
    end else begin
      ack <= req && !ack;
      if (req && !ack) begin
        if (we) mem_m[addr[7:0]] <= wdata;
        rdata <= mem_m[addr[7:0]];
      end
      if (ack && we) wr_acks <= wr_acks + 1;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic spi_xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0; mosi = t[i];
      repeat (8) @(negedge clk);
      r[i] = miso; sck = 1'b1;
      repeat (7) @(negedge clk);
    end
  endtask

  task automatic run_win(input logic [1:0] s, input int n);
    @(negedge clk); sel_n = s;
    repeat (6) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic [7:0] r;
      spi_xfer(tx_buf[k], r);
      rx_buf[k] = r;
    end
    repeat (6) @(negedge clk); sel_n = 2'b11;
    repeat (40) @(negedge clk);
  endtask

  task automatic one(input logic [1:0] s, input logic [7:0] op);
    tx_buf[0] = op; run_win(s, 1);
  endtask

  task automatic set_addr(input logic [31:0] a);
    tx_buf[0] = 8'h80;
    for (int b = 0; b < 4; b++) tx_buf[b+1] = a[8*b +: 8];
    run_win(MEM, 5);
  endtask

  task automatic set_dir(input logic [7:0] d);
    tx_buf[0] = 8'h81; tx_buf[1] = d; run_win(MEM, 2);
  endtask

  task automatic start_read(input int n);
    tx_buf[0] = 8'h84; tx_buf[1] = 8'(n - 1); tx_buf[2] = 8'((n - 1) >> 8);
    run_win(MEM, 3);
    repeat (100) @(negedge clk);
  endtask

  task automatic stream_read(input int n);
    tx_buf[0] = 8'hA0;
    for (int k = 1; k <= n; k++) tx_buf[k] = 8'h00;
    run_win(MEM, n + 1);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 srst", srst, 0); chk("R1 cfg", cfg, 0); chk("R1 req", req, 0);
    chk("R1 addr", addr, 0); chk("R1 und", und, 0); chk("R1 miso", miso, 0);

    // R5
    tx_buf[0] = 8'h23; tx_buf[1] = 8'h68; tx_buf[2] = 8'h02; run_win(SYS, 3);
    chk("R5 cfg", cfg, 32'h0268);
    // R4
    one(SYS, 8'h11); chk("R4 set", srst, 1);
    one(SYS, 8'h10); chk("R4 clr", srst, 0);
    // R6
    set_addr(32'h44332211); chk("R6 addr", addr, 32'h44332211);

    // R8 / R13 write stream
    set_addr(32'h20); set_dir(8'h00);
    @(negedge clk); wr_acks = 0;
    tx_buf[0] = 8'hB0;
    for (int i = 0; i < 16; i++) tx_buf[i+1] = 8'hC0 + 8'(i);
    run_win(MEM, 17);
    chk("R13 acks", wr_acks, 16);
    chk("R8 addr", addr, 32'h30);
    for (int i = 0; i < 16; i++) chk("R8 data", mem_m[32+i], 8'hC0 + 8'(i));

    // R7 read direction, R10/R11 underrun
    set_dir(8'h80); set_addr(32'h20); start_read(4);
    stream_read(6);
    chk("R10 opcode byte", rx_buf[0], 0);
    for (int i = 0; i < 4; i++) chk("R2 R10 data", rx_buf[i+1], 8'hC0 + 8'(i));
    chk("R11 zero5", rx_buf[5], 0); chk("R11 zero6", rx_buf[6], 0);
    chk("R11 sticky", und, 1);

    // R9 bounded prefetch, long stream
    set_addr(32'h40); start_read(20);
    chk("R11 cleared", und, 0);
    chk("R9 depth", addr, 32'h50);
    stream_read(20);
    for (int i = 0; i < 20; i++) chk("R10 long", rx_buf[i+1], initv(64 + i));
    chk("R9 total", addr, 32'h54);
    chk("R11 none", und, 0);

    // R9/R11 length sweep
    for (int n = 1; n <= 6; n++) begin
      set_addr(32'h60 + 32'(8 * n)); start_read(n);
      chk("R11 clr", und, 0);
      stream_read(n + 1);
      for (int i = 0; i < n; i++) chk("R9 sweep", rx_buf[i+1], initv(96 + 8 * n + i));
      chk("R11 tail", rx_buf[n+1], 0);
      chk("R11 flag", und, 1);
    end

    // R8 ignored in read direction
    set_addr(32'h80);
    tx_buf[0] = 8'hB0; tx_buf[1] = 8'hEE; tx_buf[2] = 8'hEE; run_win(MEM, 3);
    chk("R8 ign data", mem_m[128], initv(128));
    chk("R8 ign addr", addr, 32'h80);
    // R9 ignored in write direction
    set_dir(8'h00); start_read(3);
    chk("R9 ign", addr, 32'h80);

    // R12
    set_addr(32'h99);
    one(SYS, 8'h11); chk("R4 on", srst, 1); chk("R12 addr", addr, 32'h99);
    tx_buf[0] = 8'hB0; tx_buf[1] = 8'h5C; run_win(MEM, 2);
    chk("R12 write", mem_m[153], 8'h5C); chk("R12 next", addr, 32'h9A);
    one(SYS, 8'h10); chk("R12 keep", addr, 32'h9A);

    // R3 channel selection
    one(2'b00, 8'h11); chk("R3 both low", srst, 0);
    one(MEM, 8'h11); chk("R3 mem srst", srst, 0);
    tx_buf[0] = 8'h80; tx_buf[1] = 8'h01; tx_buf[2] = 8'h02;
    tx_buf[3] = 8'h03; tx_buf[4] = 8'h04; run_win(SYS, 5);
    chk("R3 sys addr", addr, 32'h9A);
    tx_buf[0] = 8'h23; tx_buf[1] = 8'h12; tx_buf[2] = 8'h34; run_win(MEM, 3);
    chk("R3 mem cfg", cfg, 32'h0268);

    summary();
  end
endmodule